// File: doc/BRIEF.md
# Serial Port Data FIFO Register

This block is the bus-visible data register of a synchronous serial port, together with the two queues behind it and the shifter that moves words on and off the wire. A bus write stores the low half of the 32-bit word in a transmit queue. A bus read takes the oldest word from a receive queue. When the port is enabled and the transmit queue holds a word, the shifter takes that word and shifts it out one bit per bit strobe, most significant used bit first. During the same frame it shifts the incoming line in at the least significant end. The assembled frame goes into the receive queue, right-justified.

The frame length can be programmed from 4 to 16 bits. A three-wire master mode forces every transmitted frame to 8 bits. Disabling the port stops new frames from starting, but it does not flush either queue. Software can therefore load the transmit queue before it turns the port on. Bit-rate generation is outside this block: a one-cycle `bit_tick` strobe marks each bit time.

Top module: `ssp_data_port`

## Requirements
- R1: Bits 31:16 of `bus_rdata` always read as zero, and bits 31:16 of a written word have no effect on any transmitted frame.
- R2: Each cycle with `bus_wr` high stores `bus_wdata[15:0]` at the tail of the transmit queue. Words are transmitted in the order they were written.
- R3: `bus_rdata[15:0]` shows the oldest receive-queue word, and a cycle with `bus_rd` high removes it. When the queue is empty, the read value is zero and a read has no effect.
- R4: A frame starts one cycle after the port is enabled and idle with a non-empty transmit queue, and `shift_busy` rises at that point. `tx_line` first shows bit (length-1) of the word, and steps to the next lower bit after each `bit_tick`. `tx_line` is 0 whenever no frame is active.
- R5: The `frame_size` field holds the frame length minus one. Field values 0 to 2 act as 3, so the shortest frame is 4 bits. Word bits at and above the frame length are ignored on transmit.
- R6: The frame is sampled from `rx_line` once per `bit_tick` and shifted in at bit 0. The stored word is right-justified, and all bits above the frame length are zero.
- R7: When `mw_master` is 1, every frame is 8 bits long whatever `frame_size` holds, so the upper byte of the written word is ignored.
- R8: While `port_en` is 0 no new frame starts, `tx_line` stays 0 and `bit_tick` has no effect. Queued words are kept and are sent after `port_en` returns to 1.
- R9: Each queue holds 8 words. `tx_full`/`tx_empty` and `rx_full`/`rx_empty` report the queue state, and a write to a full transmit queue is dropped.
- R10: A frame that completes while the receive queue is full is discarded and sets `rx_overrun`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the data register |
| bus_wdata | input | 32 | Write data; only bits 15:0 are used |
| bus_rd | input | 1 | Read strobe for the data register (pops the receive queue) |
| bus_rdata | output | 32 | Oldest receive word, zero-extended |
| port_en | input | 1 | Port enable |
| frame_size | input | 4 | Frame length minus one |
| mw_master | input | 1 | Three-wire master mode: forces 8-bit frames |
| bit_tick | input | 1 | One-cycle bit-time strobe |
| rx_line | input | 1 | Serial receive input |
| tx_line | output | 1 | Serial transmit output |
| shift_busy | output | 1 | A frame is in progress |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_overrun | output | 1 | Sticky flag: a received frame was dropped |

## Verification
The hardest case to reach is a frame that completes while the receive queue is already full, together with a write to a full transmit queue. The stimulus first holds the port disabled and writes nine words, so the ninth write meets a full queue. It then enables the port and clocks eight frames without reading, which fills the receive queue. One more frame then overruns it. Reading the queue back shows that the eight stored words are exactly the first eight frames, in order.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int WORD_W     = 16;
    localparam int BUS_W      = 32;
    localparam int FIFO_DEPTH = 8;
    localparam int SIZE_W     = $clog2(WORD_W);
    localparam int MIN_LEN_M1 = 3;
    localparam int MW_LEN_M1  = 7;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = empty ? '0 : mem[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (push_ok) st_d.wp = bump(st_q.wp);
        if (pop_ok)  st_d.rp = bump(st_q.rp);
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wp] <= wdata;
    end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [W-1:0]         start_word,
    input  logic [$clog2(W)-1:0] len_m1,
    input  logic                 bit_tick,
    input  logic                 rx_line,
    output logic                 tx_line,
    output logic                 busy,
    output logic                 done,
    output logic [W-1:0]         rx_word
);
    localparam int CW = $clog2(W);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [CW-1:0] len;
        logic [W-1:0]  txsh;
        logic [W-1:0]  rxsh;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic [W-1:0] rx_next;
    logic [W-1:0] len_mask;

    assign rx_next  = {st_q.rxsh[W-2:0], rx_line};
    assign len_mask = {W{1'b1}} >> (CW'(W - 1) - st_q.len);
    assign done     = st_q.busy && bit_tick && (st_q.cnt == '0);
    assign rx_word  = rx_next & len_mask;
    assign busy     = st_q.busy;
    assign tx_line  = st_q.busy ? st_q.txsh[st_q.cnt] : 1'b0;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.cnt  = len_m1;
                st_d.len  = len_m1;
                st_d.txsh = start_word;
                st_d.rxsh = '0;
            end
        end else if (bit_tick) begin
            st_d.rxsh = rx_next;
            if (st_q.cnt == '0) st_d.busy = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ssp_data_port.sv
module ssp_data_port
    import ssp_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              port_en,
    input  logic [SIZE_W-1:0] frame_size,
    input  logic              mw_master,
    input  logic              bit_tick,
    input  logic              rx_line,
    output logic              tx_line,
    output logic              shift_busy,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              rx_overrun
);
    localparam int PAD_W = BUS_W - WORD_W;

    typedef struct packed {
        logic overrun;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [WORD_W-1:0] tx_head, rx_head, rx_word, tx_mask;
    logic [SIZE_W-1:0] eff_len_m1;
    logic              start, frame_done, rx_push;

    always_comb begin
        if (mw_master)                           eff_len_m1 = SIZE_W'(MW_LEN_M1);
        else if (frame_size < SIZE_W'(MIN_LEN_M1)) eff_len_m1 = SIZE_W'(MIN_LEN_M1);
        else                                     eff_len_m1 = frame_size;
    end

    assign tx_mask   = {WORD_W{1'b1}} >> (SIZE_W'(WORD_W - 1) - eff_len_m1);
    assign start     = port_en && !shift_busy && !tx_empty;
    assign rx_push   = frame_done && !rx_full;
    assign bus_rdata = {{PAD_W{1'b0}}, rx_head};
    assign rx_overrun = st_q.overrun;

    ssp_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (bus_wr),
        .pop   (start),
        .wdata (bus_wdata[WORD_W-1:0]),
        .rdata (tx_head),
        .full  (tx_full),
        .empty (tx_empty)
    );

    ssp_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .pop   (bus_rd),
        .wdata (rx_word),
        .rdata (rx_head),
        .full  (rx_full),
        .empty (rx_empty)
    );

    ssp_shifter #(.W(WORD_W)) u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_word (tx_head & tx_mask),
        .len_m1     (eff_len_m1),
        .bit_tick   (bit_tick),
        .rx_line    (rx_line),
        .tx_line    (tx_line),
        .busy       (shift_busy),
        .done       (frame_done),
        .rx_word    (rx_word)
    );

    always_comb begin
        st_d = st_q;
        if (frame_done && rx_full) st_d.overrun = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ssp_data_port_chk.sv
module ssp_data_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] bus_rdata,
    input logic        port_en,
    input logic        tx_line,
    input logic        shift_busy,
    input logic        tx_full,
    input logic        tx_empty,
    input logic        rx_full,
    input logic        rx_empty,
    input logic        rx_overrun
);
    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:16] == 16'h0);

    p_empty_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> (bus_rdata == 32'h0));

    p_idle_line_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_busy |-> !tx_line);

    p_no_start_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en && !shift_busy) |=> !shift_busy);

    p_tx_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty));

    p_rx_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_full && rx_empty));

    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> rx_overrun);

    p_overrun_needs_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> $past(rx_full));
endmodule

bind ssp_data_port ssp_data_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rdata  (bus_rdata),
    .port_en    (port_en),
    .tx_line    (tx_line),
    .shift_busy (shift_busy),
    .tx_full    (tx_full),
    .tx_empty   (tx_empty),
    .rx_full    (rx_full),
    .rx_empty   (rx_empty),
    .rx_overrun (rx_overrun)
);

// File: tb/ssp_data_port_bench.sv
`timescale 1ns/1ps
module ssp_data_port_bench;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        port_en = 1'b0;
    logic [3:0]  frame_size = 4'd7;
    logic        mw_master = 1'b0;
    logic        bit_tick = 1'b0;
    logic        rx_line = 1'b0;
    logic        tx_line, shift_busy, tx_full, tx_empty, rx_full, rx_empty, rx_overrun;

    int checks = 0;
    int failures = 0;

    always #(CLK_NS/2) clk = ~clk;

    ssp_data_port u_ssp_data_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .port_en(port_en),
        .frame_size(frame_size), .mw_master(mw_master), .bit_tick(bit_tick),
        .rx_line(rx_line), .tx_line(tx_line), .shift_busy(shift_busy),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full),
        .rx_empty(rx_empty), .rx_overrun(rx_overrun)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_word(input logic [31:0] w);
        @(negedge clk); bus_wr = 1'b1; bus_wdata = w;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd_word(output logic [31:0] w);
        @(negedge clk); w = bus_rdata; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    // Waits for a frame to start, then clocks nbits bit strobes.
    task automatic run_frame(input int nbits, input logic [15:0] rx_val, output logic [15:0] sent);
        int guard = 0;
        sent = '0;
        bit_tick = 1'b0;
        @(negedge clk);
        while (!shift_busy && guard < 50) begin
            @(negedge clk); guard++;
        end
        check("R4 frame start", {31'h0, shift_busy}, 32'h1);
        for (int i = nbits - 1; i >= 0; i--) begin
            sent[i]  = tx_line;
            rx_line  = rx_val[i];
            bit_tick = 1'b1;
            @(negedge clk);
        end
        bit_tick = 1'b0;
        rx_line  = 1'b0;
    endtask

    task automatic t_reset;
        check("R3 reset read", bus_rdata, 32'h0);
        check("R9 reset flags", {28'h0, tx_full, tx_empty, rx_full, rx_empty}, 32'h5);
        check("R4 reset line", {31'h0, tx_line}, 32'h0);
        check("R10 reset overrun", {31'h0, rx_overrun}, 32'h0);
    endtask

    task automatic t_basic8;
        logic [15:0] s; logic [31:0] r;
        port_en = 1'b1; frame_size = 4'd7;
        wr_word(32'hFFFF_A5C3);
        run_frame(8, 16'h005A, s);
        check("R2 R5 8-bit tx", {16'h0, s}, 32'h0000_00C3);
        @(negedge clk);
        check("R4 line idle after frame", {30'h0, shift_busy, tx_line}, 32'h0);
        rd_word(r);
        check("R6 R1 8-bit rx", r, 32'h0000_005A);
        check("R3 empty after pop", {31'h0, rx_empty}, 32'h1);
    endtask

    task automatic t_sizes;
        logic [15:0] s; logic [31:0] r;
        frame_size = 4'd15;
        wr_word(32'h1234_8001);
        run_frame(16, 16'hBEEF, s);
        check("R4 16-bit tx", {16'h0, s}, 32'h0000_8001);
        rd_word(r);
        check("R6 16-bit rx", r, 32'h0000_BEEF);
        frame_size = 4'd1;
        wr_word(32'h0000_123D);
        run_frame(4, 16'hFFFF, s);
        check("R5 clamp to 4-bit tx", {16'h0, s}, 32'h0000_000D);
        @(negedge clk);
        check("R5 4-bit frame ended", {31'h0, shift_busy}, 32'h0);
        rd_word(r);
        check("R6 4-bit rx upper zero", r, 32'h0000_000F);
    endtask

    task automatic t_microwire;
        logic [15:0] s; logic [31:0] r;
        frame_size = 4'd11; mw_master = 1'b1;
        wr_word(32'h0000_0F96);
        run_frame(8, 16'hFFFF, s);
        check("R7 8-bit tx", {16'h0, s}, 32'h0000_0096);
        @(negedge clk);
        check("R7 frame ends after 8", {31'h0, shift_busy}, 32'h0);
        rd_word(r);
        check("R7 8-bit rx", r, 32'h0000_00FF);
        mw_master = 1'b0;
    endtask

    task automatic t_preload;
        logic [15:0] s; logic [31:0] r;
        port_en = 1'b0; frame_size = 4'd7;
        wr_word(32'h0000_0033);
        wr_word(32'h0000_00CC);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); bit_tick = 1'b1; rx_line = 1'b1;
        end
        @(negedge clk); bit_tick = 1'b0; rx_line = 1'b0;
        check("R8 no frame while disabled", {29'h0, shift_busy, tx_line, tx_empty}, 32'h0);
        check("R8 rx untouched while disabled", {31'h0, rx_empty}, 32'h1);
        port_en = 1'b1;
        run_frame(8, 16'h0001, s);
        check("R8 first preloaded word", {16'h0, s}, 32'h0000_0033);
        run_frame(8, 16'h0002, s);
        check("R8 second preloaded word", {16'h0, s}, 32'h0000_00CC);
        rd_word(r); check("R3 rx order 1", r, 32'h1);
        rd_word(r); check("R3 rx order 2", r, 32'h2);
        rd_word(r); check("R3 empty read returns zero", r, 32'h0);
        check("R3 empty read no effect", {31'h0, rx_empty}, 32'h1);
    endtask

    task automatic t_full_overrun;
        logic [15:0] s; logic [31:0] r;
        port_en = 1'b0;
        for (int i = 0; i < 9; i++) wr_word(32'h10 + i);
        check("R9 tx full", {30'h0, tx_full, tx_empty}, 32'h2);
        port_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            run_frame(8, 16'hA0 + 16'(i), s);
            check("R2 R9 queue order", {16'h0, s}, 32'h10 + i);
        end
        repeat (3) @(negedge clk);
        check("R9 ninth write dropped", {30'h0, shift_busy, tx_empty}, 32'h1);
        check("R9 rx full", {30'h0, rx_full, rx_overrun}, 32'h2);
        wr_word(32'h77);
        run_frame(8, 16'h55, s);
        @(negedge clk);
        check("R10 overrun set", {30'h0, rx_full, rx_overrun}, 32'h3);
        for (int i = 0; i < 8; i++) begin
            rd_word(r);
            check("R10 stored frames intact", r, 32'hA0 + i);
        end
        check("R10 overrun sticky", {30'h0, rx_empty, rx_overrun}, 32'h3);
    endtask

    initial begin
        #(CLK_NS * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic8();
        t_sizes();
        t_microwire();
        t_preload();
        t_full_overrun();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule